// File: doc/BRIEF.md
# Configuration Bus Register Endpoint

This block is one endpoint on a narrow, synchronous configuration bus. The bus carries a 14-bit address, a single write-enable line, a 32-bit write word and a 32-bit read word. There is no handshake and no wait state. The top four address bits name a slave. The endpoint answers only when that field equals its parameter `SLAVE_ID`. The low ten bits pick a word slot inside the endpoint.

The endpoint holds `N_CTRL` read/write control words, which drive the peripheral through `ctrl_out`. After them in the slot space come `N_STAT` read-only status words, taken from `stat_in` when they are read. Every other slot reads as zero and ignores writes.

Read data is registered and appears one cycle after the address. A new address may be presented on every cycle. The endpoint drives zero on the read lines whenever it was not addressed by a read in the previous cycle, and also after any write. Many endpoints can therefore share one master by ORing their read words together, with no multiplexer.

Top module: `cfgbus_regbank`

## Requirements
- R1: While reset is asserted, and after it is released, every control word and the read word are zero until a write changes them.
- R2: A read (write enable low) of control slot k in this slave returns that word on `bus_rdata` in the cycle after the address is presented.
- R3: Reads presented on consecutive cycles each return their own data, one cycle after their own address.
- R4: If address bits [13:10] in the previous cycle did not equal `SLAVE_ID`, `bus_rdata` is all zero.
- R5: A write (write enable high) to control slot k of this slave with data D makes `ctrl_out[32k+31:32k]` equal D after the next clock edge.
- R6: A write whose bits [13:10] differ from `SLAVE_ID` changes no control word.
- R7: Writes on consecutive cycles to different control slots all take effect.
- R8: In the cycle after any write, selected or not, `bus_rdata` is zero.
- R9: A read of slot `N_CTRL+j` returns the value `stat_in[32j+31:32j]` held at the clock edge that ends the address cycle. Writes to that slot change nothing.
- R10: A read of a slot at or above `N_CTRL+N_STAT` returns zero, and a write to such a slot changes no control word.
- R11: The slave field is address bits [13:10] and the slot index is bits [9:0]. The same index under another slave field is not answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 14 | Slave field [13:10], slot index [9:0] |
| bus_we | input | 1 | High for write, low for read |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Registered read word, zero when not addressed |
| ctrl_out | output | 32*N_CTRL | Control words, slot k at bits [32k+31:32k] |
| stat_in | input | 32*N_STAT | Status words, slot N_CTRL+j at bits [32j+31:32j] |

## Verification
The hardest case to reach is a write that must not take effect: a write to another slave, to a status slot, or to a slot past the map. Its only trace is the absence of a change. The stimulus table puts such writes between writes and reads of real control slots. Later read-backs of those slots, and a final compare of `ctrl_out`, show that the earlier values survived. Because the table is walked with no idle cycles, back-to-back reads and writes both see their results exactly one cycle after the address.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;
  localparam int CB_ADDR_W = 14;
  localparam int CB_SEL_W  = 4;
  localparam int CB_DATA_W = 32;
  localparam int CB_IDX_W  = CB_ADDR_W - CB_SEL_W;

  typedef enum logic [1:0] {
    SLOT_NONE = 2'd0,
    SLOT_CTRL = 2'd1,
    SLOT_STAT = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/cfgbus_decode.sv
module cfgbus_decode
  import cfgbus_pkg::*;
#(
  parameter logic [CB_SEL_W-1:0] SLAVE_ID = 4'd6,
  parameter int N_CTRL = 4,
  parameter int N_STAT = 2
) (
  input  logic [CB_ADDR_W-1:0] addr,
  input  logic                 we,
  output logic                 hit,
  output slot_kind_e           kind,
  output logic [CB_IDX_W-1:0]  offset,
  output logic [N_CTRL-1:0]    wr_vec
);
  localparam int SLOT_END = N_CTRL + N_STAT;

  logic [CB_IDX_W-1:0] idx;

  assign idx = addr[CB_IDX_W-1:0];
  assign hit = (addr[CB_ADDR_W-1:CB_IDX_W] == SLAVE_ID);

  always_comb begin
    kind   = SLOT_NONE;
    offset = '0;
    if (int'(idx) < N_CTRL) begin
      kind   = SLOT_CTRL;
      offset = idx;
    end else if (int'(idx) < SLOT_END) begin
      kind   = SLOT_STAT;
      offset = CB_IDX_W'(int'(idx) - N_CTRL);
    end
  end

  always_comb begin
    for (int i = 0; i < N_CTRL; i++) begin
      wr_vec[i] = hit && we && (kind == SLOT_CTRL) && (int'(offset) == i);
    end
  end

  always_comb begin
    AST_DEC_NO_FOREIGN_WRITE: assert (hit || (wr_vec == '0)); // R6
  end
endmodule

// File: rtl/cfgbus_ctrl_regs.sv
module cfgbus_ctrl_regs
  import cfgbus_pkg::*;
#(
  parameter int N_CTRL = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_CTRL-1:0]    wr_vec,
  input  logic [CB_DATA_W-1:0] wdata,
  output logic [CB_DATA_W-1:0] ctrl_q [N_CTRL]
);
  logic [CB_DATA_W-1:0] ctrl_d [N_CTRL];

  genvar g;
  generate
    for (g = 0; g < N_CTRL; g++) begin : g_word
      always_comb begin
        ctrl_d[g] = ctrl_q[g];
        if (wr_vec[g]) ctrl_d[g] = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q[g] <= '0;
        else if (wr_vec[g]) ctrl_q[g] <= ctrl_d[g];
      end

      AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vec[g] |=> (ctrl_q[g] == $past(wdata))); // R5
      AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_vec[g] |=> $stable(ctrl_q[g])); // R6
    end
  endgenerate

  AST_CTRL_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec)); // R7
endmodule

// File: rtl/cfgbus_rdata.sv
module cfgbus_rdata
  import cfgbus_pkg::*;
#(
  parameter int N_CTRL = 4,
  parameter int N_STAT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hit,
  input  logic                 we,
  input  slot_kind_e           kind,
  input  logic [CB_IDX_W-1:0]  offset,
  input  logic [CB_DATA_W-1:0] ctrl_q [N_CTRL],
  input  logic [CB_DATA_W-1:0] stat_w [N_STAT],
  output logic [CB_DATA_W-1:0] rdata
);
  logic [CB_DATA_W-1:0] word_sel;
  logic [CB_DATA_W-1:0] rdata_d;
  logic                 rd_go;

  assign rd_go = hit && !we;

  always_comb begin
    word_sel = '0;
    if (kind == SLOT_CTRL) begin
      for (int i = 0; i < N_CTRL; i++) begin
        if (int'(offset) == i) word_sel = ctrl_q[i];
      end
    end else if (kind == SLOT_STAT) begin
      for (int j = 0; j < N_STAT; j++) begin
        if (int'(offset) == j) word_sel = stat_w[j];
      end
    end
  end

  always_comb begin
    rdata_d = rd_go ? word_sel : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

  AST_RD_QUIET_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata == '0)); // R8
  AST_RD_QUIET_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (rdata == '0)); // R4
  AST_RD_EMPTY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == SLOT_NONE) |=> (rdata == '0)); // R10
endmodule

// File: rtl/cfgbus_regbank.sv
module cfgbus_regbank
  import cfgbus_pkg::*;
#(
  parameter logic [CB_SEL_W-1:0] SLAVE_ID = 4'd6,
  parameter int N_CTRL = 4,
  parameter int N_STAT = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CB_ADDR_W-1:0]        bus_addr,
  input  logic                        bus_we,
  input  logic [CB_DATA_W-1:0]        bus_wdata,
  output logic [CB_DATA_W-1:0]        bus_rdata,
  output logic [N_CTRL*CB_DATA_W-1:0] ctrl_out,
  input  logic [N_STAT*CB_DATA_W-1:0] stat_in
);
  logic [1:0]           rst_sync;
  logic                 rst_int_n;
  logic                 hit;
  slot_kind_e           kind;
  logic [CB_IDX_W-1:0]  offset;
  logic [N_CTRL-1:0]    wr_vec;
  logic [CB_DATA_W-1:0] ctrl_q [N_CTRL];
  logic [CB_DATA_W-1:0] stat_w [N_STAT];

  // reset asserts at once and leaves two edges after rst_n rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  genvar g;
  generate
    for (g = 0; g < N_CTRL; g++) begin : g_ctrl_flat
      assign ctrl_out[g*CB_DATA_W +: CB_DATA_W] = ctrl_q[g];
    end
    for (g = 0; g < N_STAT; g++) begin : g_stat_unflat
      assign stat_w[g] = stat_in[g*CB_DATA_W +: CB_DATA_W];
    end
  endgenerate

  cfgbus_decode #(
    .SLAVE_ID (SLAVE_ID),
    .N_CTRL   (N_CTRL),
    .N_STAT   (N_STAT)
  ) u_decode (
    .addr   (bus_addr),
    .we     (bus_we),
    .hit    (hit),
    .kind   (kind),
    .offset (offset),
    .wr_vec (wr_vec)
  );

  cfgbus_ctrl_regs #(
    .N_CTRL (N_CTRL)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_vec (wr_vec),
    .wdata  (bus_wdata),
    .ctrl_q (ctrl_q)
  );

  cfgbus_rdata #(
    .N_CTRL (N_CTRL),
    .N_STAT (N_STAT)
  ) u_rdata (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .hit    (hit),
    .we     (bus_we),
    .kind   (kind),
    .offset (offset),
    .ctrl_q (ctrl_q),
    .stat_w (stat_w),
    .rdata  (bus_rdata)
  );

  AST_TOP_FOREIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_addr[CB_ADDR_W-1:CB_IDX_W] != SLAVE_ID) |=> (bus_rdata == '0)); // R11
  AST_TOP_STAT_READ: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!bus_we && bus_addr == {SLAVE_ID, CB_IDX_W'(N_CTRL)})
      |=> (bus_rdata == $past(stat_in[CB_DATA_W-1:0]))); // R9
  AST_TOP_CTRL0_READ: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!bus_we && bus_addr == {SLAVE_ID, CB_IDX_W'(0)} && !wr_vec[0])
      |=> (bus_rdata == ctrl_out[CB_DATA_W-1:0])); // R2
endmodule

// File: tb/cfgbus_regbank_tb.sv
module cfgbus_regbank_tb;
  localparam logic [3:0] SID = 4'd6;
  localparam int NC = 4;
  localparam int NS = 2;
  localparam logic [31:0] ST0 = 32'hA5A5_0001;
  localparam logic [31:0] ST1 = 32'h5A5A_0002;
  localparam int NV = 16;

  // {we, slave[3:0], index[9:0], wdata[31:0], expected rdata next cycle[31:0]}
  localparam logic [78:0] VEC [NV] = '{
    {1'b1, 4'd6,  10'd0,    32'h1111_1111, 32'h0},           // R7 write 0
    {1'b1, 4'd6,  10'd1,    32'h2222_2222, 32'h0},           // R7 write 1 back-to-back
    {1'b0, 4'd6,  10'd0,    32'h0,         32'h1111_1111},   // R2 R3
    {1'b0, 4'd6,  10'd1,    32'h0,         32'h2222_2222},   // R3
    {1'b0, 4'd5,  10'd1,    32'h0,         32'h0},           // R4
    {1'b1, 4'd3,  10'd2,    32'hDEAD_BEEF, 32'h0},           // R6 R8
    {1'b0, 4'd6,  10'd2,    32'h0,         32'h0},           // R6
    {1'b0, 4'd6,  10'd4,    32'h0,         ST0},             // R9
    {1'b0, 4'd6,  10'd5,    32'h0,         ST1},             // R9
    {1'b1, 4'd6,  10'd4,    32'hFFFF_FFFF, 32'h0},           // R9 R8
    {1'b0, 4'd6,  10'd4,    32'h0,         ST0},             // R9
    {1'b0, 4'd6,  10'd6,    32'h0,         32'h0},           // R10
    {1'b1, 4'd6,  10'd1023, 32'h1234_5678, 32'h0},           // R10
    {1'b0, 4'd6,  10'd3,    32'h0,         32'h0},           // R10
    {1'b0, 4'd6,  10'd1,    32'h0,         32'h2222_2222},   // R10
    {1'b0, 4'd12, 10'd1,    32'h0,         32'h0}            // R11
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [13:0]   bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NC*32-1:0] ctrl_out;
  logic [NS*32-1:0] stat_in = {ST1, ST0};

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cfgbus_regbank #(.SLAVE_ID(SID), .N_CTRL(NC), .N_STAT(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_out(ctrl_out),
    .stat_in(stat_in)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle_cycles(3);
    check("R1 rdata in reset", 128'(bus_rdata), 128'h0);
    check("R1 ctrl in reset", 128'(ctrl_out), 128'h0);
    rst_n = 1'b1;
    idle_cycles(4);
    check("R1 ctrl after release", 128'(ctrl_out), 128'h0);

    // table walk, one vector per cycle, each checked one cycle later
    for (int v = 0; v < NV; v++) begin
      bus_we    = VEC[v][78];
      bus_addr  = VEC[v][77:64];
      bus_wdata = VEC[v][63:32];
      @(negedge clk);
      check($sformatf("vector %0d R2/R3/R4/R8/R9/R10/R11", v),
            128'(bus_rdata), 128'(VEC[v][31:0]));
    end
    bus_we = 1'b0;
    bus_addr = {4'd0, 10'd0};
    @(negedge clk);
    check("R6 R10 ctrl image", 128'(ctrl_out),
          {32'h0, 32'h0, 32'h2222_2222, 32'h1111_1111});

    // R5: write visible after exactly one edge
    bus_we = 1'b1; bus_addr = {SID, 10'd3}; bus_wdata = 32'hCAFE_F00D;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = '0;
    check("R5 ctrl slot 3", 128'(ctrl_out[127:96]), 128'hCAFE_F00D);
    check("R8 rdata after write", 128'(bus_rdata), 128'h0);

    // R9: status value held at the address edge
    bus_addr = {SID, 10'd5};
    stat_in[63:32] = 32'h0BAD_CAFE;
    @(negedge clk);
    stat_in[63:32] = ST1;
    bus_addr = '0;
    check("R9 status sample", 128'(bus_rdata), 128'h0BAD_CAFE);

    // R1: reset in mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 ctrl mid reset", 128'(ctrl_out), 128'h0);
    check("R1 rdata mid reset", 128'(bus_rdata), 128'h0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule